// File: doc/BRIEF.md
# Flash Access Portal Command Engine

This block lets a local controller reach an attached SPI flash array through a shared access path by loading a few registers instead of driving the serial bus itself. Software writes a flash address, a local buffer address and a command word that holds the operation type and a length. It then writes the start register. The engine checks the request, routes it to one of two chip selects, and issues it on a simple backend request/acknowledge interface. Software then polls status or waits for the interrupt.

Checks cover the command type, the byte count for reads and writes, the supported erase size and whether the whole span fits inside the configured flash capacity. A rejected request sets an error bit and the done bit, and it never reaches the backend. An accepted request holds the backend request until it is acknowledged. If no acknowledge arrives within a programmable number of cycles, the operation is aborted with a timeout error. Capacity, split point, erase capability and timeout form the configuration, and they cannot be changed while the portal is enabled.

Register map (wr_addr/rd_addr): 0 control (bit0 enable, bit1 done interrupt enable), 1 flash address, 2 buffer address, 3 command (bits 1:0 type, bits 14:8 length), 4 start (bit0), 5 status (bit0 done, bit1 bad type, bit2 bad length, bit3 bad erase size, bit4 out of range, bit5 timeout, bit6 disabled; bit8 busy is read-only), 6 chip-select threshold, 7 size limit, 8 erase capability (bit0 4 KB, bit1 32 KB, bit2 64 KB), 9 timeout limit.

Top module: `flash_portal`

## Requirements
- R1: Command type 0 is read, 1 is write and 2 is erase. A start with type 3 sets status bit1 and done (value 0x03) and issues no backend request.
- R2: For read and write, a length field (command bits 14:8) of 0 or above 64 sets status bit2 and done (0x05) with no backend request. Lengths 1 to 64 are accepted.
- R3: For erase, the length field is a size code (0 = 4 KB, 1 = 32 KB, 2 = 64 KB). A code above 2, or a code whose bit in the erase capability register is 0, sets status bit3 and done (0x09). Capability bit0 (4 KB) always reads 1, whatever value is written.
- R4: An accepted start sets busy (status bit8) and the backend request. Writes to start, flash address, buffer address or command while busy have no effect.
- R5: Writing 1 to a bit of status bits 6:0 clears that bit. Writing 0 leaves it unchanged.
- R6: A start while control bit0 is 0 sets status bit6 and done (0x41) and issues no backend request.
- R7: While control bit0 is 1, writes to the threshold, size limit, erase capability and timeout registers are ignored.
- R8: An address below the threshold goes to chip select 0 with the same offset. An address at or above it goes to chip select 1 with offset equal to address minus threshold.
- R9: A request whose last byte (address plus byte count or erase size, minus one) exceeds the size limit sets status bit4 and done (0x11) with no backend request.
- R10: If the request is not acknowledged by the cycle on which the request-cycle count equals the timeout limit, busy clears and status bit5 and done are set (0x21).
- R11: irq is 1 exactly while status done and control bit1 are both 1.
- R12: An acknowledge clears busy and the request and sets done (0x01). While requested, the backend sees type, length, buffer address, chip select and offset. Checks are prioritized as disabled, then type, then length/erase size, then range, and only the first failing check sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read index |
| rd_data | output | 32 | Register read data (combinational) |
| be_req | output | 1 | Backend request, held until acknowledge or timeout |
| be_cs | output | 1 | Selected chip select |
| be_type | output | 2 | Operation type |
| be_len | output | 7 | Byte count or erase size code |
| be_addr | output | AW | Offset within the selected device |
| be_buf | output | 32 | Local buffer address |
| be_ack | input | 1 | Backend acknowledge |
| irq | output | 1 | Done interrupt |

## Verification
On every cycle, the assertions check that an acknowledge ends the request and raises done, and that command writes during busy leave the command unchanged. They also check that a frozen threshold holds while enabled, that a start while disabled never raises a request, that accepted read and write lengths lie in range, and that a request ended without acknowledge leaves the timeout bit. The request priority and the exact status codes are checked only by the bench scenarios, which include random mixes of types, lengths and addresses around the threshold and the size limit. The bench scenarios also cover the chip-select offset, a partly supported erase capability, the single transfer that results from a repeated start, and the interrupt clearing with done.

// File: rtl/flash_portal.sv
module flash_portal #(
  parameter int AW     = 24,
  parameter int TW     = 16,
  parameter int MAXLEN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          be_req,
  output logic          be_cs,
  output logic [1:0]    be_type,
  output logic [6:0]    be_len,
  output logic [AW-1:0] be_addr,
  output logic [31:0]   be_buf,
  input  logic          be_ack,
  output logic          irq
);
  localparam int LW = 7;

  logic          en, die, busy;
  logic [AW-1:0] faddr, thresh, sizelim;
  logic [31:0]   bufa;
  logic [1:0]    ctype;
  logic [LW-1:0] clen;
  logic [2:0]    ecap;
  logic [TW-1:0] tmo, cnt;
  logic [6:0]    sts, sts_set, err;
  logic [AW:0]   span, last;

  function automatic logic wr(input logic [3:0] a);
    return wr_en && wr_addr == a;
  endfunction

  wire is_rw    = ctype < 2'd2;
  wire type_bad = ctype == 2'd3;
  wire len_bad  = is_rw && (clen == '0 || clen > LW'(MAXLEN));
  wire [3:0] capx = {1'b0, ecap};
  wire code_bad = ctype == 2'd2 && (clen > LW'(2) || !capx[clen[1:0]]);

  always_comb begin
    case ({is_rw, clen[1:0]})
      3'b000:  span = (AW+1)'(4096);
      3'b001:  span = (AW+1)'(32768);
      3'b010:  span = (AW+1)'(65536);
      default: span = (AW+1)'(clen);
    endcase
  end
  assign last = {1'b0, faddr} + span - (AW+1)'(1);
  wire range_bad = last > {1'b0, sizelim};

  always_comb begin
    err = '0;
    if (!en)                       err[6] = 1'b1;
    else if (type_bad)             err[1] = 1'b1;
    else if (len_bad)              err[2] = 1'b1;
    else if (code_bad)             err[3] = 1'b1;
    else if (range_bad)            err[4] = 1'b1;
  end

  wire start    = wr(4'd4) && wr_data[0] && !busy;
  wire timedout = busy && !be_ack && cnt == tmo;

  always_comb begin
    sts_set = '0;
    if (start && err != '0) sts_set = err | 7'd1;
    if (busy && be_ack)     sts_set[0] = 1'b1;
    if (timedout)           sts_set = 7'b0100001;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; die <= 1'b0; busy <= 1'b0; cnt <= '0; sts <= '0;
      faddr <= '0; bufa <= '0; ctype <= '0; clen <= '0;
      thresh <= '1; sizelim <= '0; ecap <= 3'b001; tmo <= TW'(64);
    end else begin
      if (wr(4'd0)) {die, en} <= wr_data[1:0];
      if (!busy) begin
        if (wr(4'd1)) faddr <= wr_data[AW-1:0];
        if (wr(4'd2)) bufa  <= wr_data;
        if (wr(4'd3)) begin ctype <= wr_data[1:0]; clen <= wr_data[8+:LW]; end
      end
      if (!en) begin
        if (wr(4'd6)) thresh  <= wr_data[AW-1:0];
        if (wr(4'd7)) sizelim <= wr_data[AW-1:0];
        if (wr(4'd8)) ecap    <= {wr_data[2:1], 1'b1};
        if (wr(4'd9)) tmo     <= wr_data[TW-1:0];
      end
      sts <= (wr(4'd5) ? sts & ~wr_data[6:0] : sts) | sts_set;
      if (start && err == '0) begin
        busy <= 1'b1; cnt <= '0;
      end else if (busy) begin
        if (be_ack || timedout) busy <= 1'b0;
        else                    cnt  <= cnt + 1'b1;
      end
    end
  end

  assign be_req  = busy;
  assign be_cs   = faddr >= thresh;
  assign be_addr = be_cs ? faddr - thresh : faddr;
  assign be_type = ctype;
  assign be_len  = clen;
  assign be_buf  = bufa;
  assign irq     = sts[0] && die;

  always_comb begin
    case (rd_addr)
      4'd0:    rd_data = {30'd0, die, en};
      4'd1:    rd_data = 32'(faddr);
      4'd2:    rd_data = bufa;
      4'd3:    rd_data = {17'd0, clen, 6'd0, ctype};
      4'd5:    rd_data = {23'd0, busy, 1'b0, sts};
      4'd6:    rd_data = 32'(thresh);
      4'd7:    rd_data = 32'(sizelim);
      4'd8:    rd_data = {29'd0, ecap};
      4'd9:    rd_data = 32'(tmo);
      default: rd_data = '0;
    endcase
  end

  p_ack_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack |=> !be_req && sts[0]);
  p_cmd_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && wr_addr == 4'd3 |=> $stable({ctype, clen}));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && wr_en && wr_addr == 4'd6 |=> $stable(thresh));
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !busy && wr_en && wr_addr == 4'd4 && wr_data[0] |=> !be_req && sts[6]);
  p_len_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) && be_type != 2'd2 |-> be_len >= 7'd1 && be_len <= 7'(MAXLEN));
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(be_ack) |-> sts[5] && sts[0]);
endmodule

// File: tb/flash_portal_test.sv
module flash_portal_test;
  localparam int CLK = 10;
  localparam int LAT = 6;
  localparam logic [23:0] THR = 24'h10000, LIM = 24'h1FFFF;

  logic clk = 0, rst_n = 0, wr_en = 0, be_ack = 0, no_ack = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data, be_buf;
  logic be_req, be_cs, irq;
  logic [1:0] be_type;
  logic [6:0] be_len;
  logic [23:0] be_addr;
  int tests = 0, fails = 0, reqs = 0, acnt = 0;
  logic r_cs; logic [1:0] r_type; logic [6:0] r_len; logic [23:0] r_addr; logic [31:0] r_buf;
  logic [2:0] cap = 3'b101;

  flash_portal uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .be_req(be_req), .be_cs(be_cs), .be_type(be_type),
    .be_len(be_len), .be_addr(be_addr), .be_buf(be_buf), .be_ack(be_ack), .irq(irq));

  always #(CLK/2) clk = ~clk;

  always @(posedge clk) if (be_req && !$past(be_req)) reqs <= reqs + 1;

  always @(negedge clk) begin
    if (be_req && !no_ack) begin
      acnt = acnt + 1;
      if (acnt == LAT) begin
        be_ack = 1; r_cs = be_cs; r_type = be_type; r_len = be_len; r_addr = be_addr; r_buf = be_buf;
      end else be_ack = 0;
    end else begin acnt = 0; be_ack = 0; end
  end

  initial begin
    #(CLK*150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic run_op(input logic [1:0] t, input logic [6:0] l, input logic [23:0] a,
                        input logic [31:0] b, output logic [31:0] st);
    wreg(1, 32'(a)); wreg(2, b); wreg(3, {17'd0, l, 6'd0, t}); wreg(4, 1);
    for (int i = 0; i < 300; i++) begin
      rreg(5, st);
      if (st[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] exp_st(input logic en, input logic [1:0] t, input logic [6:0] l,
                                          input logic [23:0] a);
    logic [24:0] sz;
    if (!en) return 32'h41;
    if (t == 3) return 32'h03;
    if (t < 2 && (l == 0 || l > 64)) return 32'h05;
    if (t == 2 && (l > 2 || !cap[l[1:0]])) return 32'h09;
    sz = (t < 2) ? 25'(l) : (l == 0 ? 25'd4096 : l == 1 ? 25'd32768 : 25'd65536);
    if ({1'b0, a} + sz - 25'd1 > {1'b0, LIM}) return 32'h11;
    return 32'h01;
  endfunction

  initial begin
    logic [31:0] v, e;
    int n0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rreg(5, v); check(v == 0, "R4 reset status/busy", v, 0);
    rreg(8, v); check(v == 1, "R3 reset capability", v, 1);
    check(!be_req && !irq, "R11 reset req/irq", {be_req, irq}, 0);

    wreg(6, 32'(THR)); wreg(7, 32'(LIM)); wreg(8, 32'h4); wreg(9, 32'd5);
    rreg(8, v); check(v == 5, "R3 capability bit0 forced", v, 5);

    run_op(0, 4, 24'h100, 32'hA0, v);
    check(v == 32'h41, "R6 start while disabled", v, 32'h41);
    check(reqs == 0, "R6 no backend request", reqs, 0);
    wreg(5, 32'h1);
    rreg(5, v); check(v == 32'h40, "R5 W1C clears only written bit", v, 32'h40);
    wreg(5, 32'h7F);

    wreg(0, 1);
    wreg(6, 32'h123);
    rreg(6, v); check(v == 32'(THR), "R7 threshold frozen", v, 32'(THR));
    wreg(9, 32'd200);
    rreg(9, v); check(v == 5, "R7 timeout frozen", v, 5);

    run_op(0, 7'd64, 24'h1FFC0, 32'hB0, v);
    check(v == 1, "R12 read at last 64 bytes", v, 1);
    check(r_cs && r_addr == 24'hFFC0 && r_len == 64 && r_buf == 32'hB0, "R8 cs1 routing",
          {7'd0, r_cs, r_addr}, 32'h100FFC0);
    wreg(5, 32'h7F);
    run_op(1, 7'd1, 24'hFFFF, 32'hC0, v);
    check(v == 1 && !r_cs && r_addr == 24'hFFFF && r_type == 1, "R8 cs0 below threshold",
          {7'd0, r_cs, r_addr}, 32'hFFFF);
    wreg(5, 32'h7F);
    run_op(0, 7'd2, 24'h1FFFF, 0, v);
    check(v == 32'h11, "R9 read past size limit", v, 32'h11);
    wreg(5, 32'h7F);
    run_op(2, 7'd2, 24'h10001, 0, v);
    check(v == 32'h11, "R9 64KB erase past limit", v, 32'h11);
    wreg(5, 32'h7F);
    run_op(2, 7'd1, 24'h0, 0, v);
    check(v == 32'h09, "R3 erase size not in capability", v, 32'h09);
    wreg(5, 32'h7F);
    run_op(3, 7'd4, 24'h0, 0, v);
    check(v == 32'h03, "R1 bad type", v, 32'h03);
    wreg(5, 32'h7F);
    run_op(1, 7'd65, 24'h0, 0, v);
    check(v == 32'h05, "R2 length 65", v, 32'h05);
    wreg(5, 32'h7F);

    n0 = reqs;
    wreg(1, 32'h40); wreg(3, 32'h0800); wreg(4, 1);
    wreg(4, 1); wreg(3, 32'h0900);
    rreg(5, v); check(v[8] == 1, "R4 busy during operation", v, 32'h100);
    for (int i = 0; i < 50; i++) begin rreg(5, v); if (v[0]) break; @(negedge clk); end
    check(reqs == n0 + 1, "R4 start while busy ignored", reqs, n0 + 1);
    check(r_len == 8, "R4 command write while busy ignored", r_len, 8);
    wreg(5, 32'h7F);

    wreg(0, 0); wreg(9, 32'd5); wreg(0, 3);
    no_ack = 1;
    run_op(0, 7'd4, 24'h0, 0, v);
    check(v == 32'h21, "R10 timeout status and busy clear", v, 32'h21);
    no_ack = 0;
    @(negedge clk);
    check(irq == 1, "R11 irq with done and enable", irq, 1);
    wreg(5, 32'h7F);
    check(irq == 0, "R11 irq cleared with done", irq, 0);
    wreg(0, 1);

    for (int k = 0; k < 60; k++) begin
      logic [1:0] t; logic [6:0] l; logic [23:0] a;
      t = 2'($urandom % 4);
      l = (t == 2) ? 7'($urandom % 4) : 7'($urandom % 72);
      a = 24'($urandom % 32'h21000);
      n0 = reqs;
      run_op(t, l, a, 32'(k), v);
      e = exp_st(1'b1, t, l, a);
      check(v == e, "R12 random op status", v, e);
      if (e == 1)
        check(r_cs == (a >= THR) && r_addr == (a >= THR ? a - THR : a) && r_len == l && r_type == t,
              "R8 random routing", {7'd0, r_cs, r_addr}, {7'd0, a >= THR, (a >= THR ? a - THR : a)});
      else
        check(reqs == n0, "R9 random reject issues nothing", reqs, n0);
      wreg(5, 32'h7F);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule